// File: doc/BRIEF.md
# Channel Start and Hop Sync Controller

This block sits beside one receive channel and turns synchronisation requests into delayed actions. A request comes either from software, which pulses a write strobe together with a Start bit and a Hop bit, or from one of several external sync pins. A select field picks which pin the channel watches. Two enables decide whether a pin edge may trigger a start, a hop, or both.

Each accepted request reloads one of two 16-bit holdoff down-counters from a programmed value. The counter steps down on every cycle where the sample-clock enable is high. When it reaches its terminal value, the block acts. The hop counter emits a one-cycle hop strobe, which tells the oscillator datapath to copy its shadow frequency word into the active word. The start counter wakes a sleeping channel by clearing the sleep flag. If the channel is already running, it instead emits a one-cycle filter-phase realign strobe, so that a periodic pin pulse keeps several channels in step.

A programmed value of 1 acts at once, and a value of 0 suppresses the action. The sleep flag can also be written directly, or through a group write that covers several channels. For a group write, this channel takes its own bit.

Top module: `chan_sync_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sleep_o` is 1 and `hop_stb` and `realign_stb` are 0.
- R2: A software hop request (`soft_wr`=1 with `soft_hop`=1) with `hop_hold`=N≥1 raises `hop_stb` at the (N−1)th clock edge after the edge that captures the write, given `sample_en`=1 throughout. For N=1 this is the capturing edge itself.
- R3: A software start request with `start_hold`=N≥1 acts with the same timing as R2. If `sleep_o` is 1, it drops to 0. If `sleep_o` is 0, `realign_stb` pulses for one cycle and `sleep_o` stays 0.
- R4: A request taken while the programmed holdoff is 0 causes no action. It also cancels a countdown of that counter that is still pending.
- R5: The pin path watches `sync_pins[pin_sel]` only. It responds to a rising edge through a two-flop synchroniser, two clock edges later than the software path. A level held high for many cycles triggers once, and edges on other pins are ignored.
- R6: A pin edge triggers the start counter only when `pin_start_en`=1, and the hop counter only when `pin_hop_en`=1.
- R7: A new request for a counter that is still counting reloads that counter from its programmed value. The count never rises except on such a load.
- R8: A counter decrements only in cycles with `sample_en`=1, and a holdoff of 1 acts on the request edge even when `sample_en`=0.
- R9: `sleep_wr` loads `sleep_o` from `sleep_wdata` at the next edge. `grp_sleep_wr` loads it from `grp_sleep_data[CHAN_SLOT]` (bit 2 by default). Both writes win over a start action in the same cycle, and only these writes can raise `sleep_o`.
- R10: Each action produces a strobe exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample-clock enable that paces both counters |
| soft_wr | input | 1 | Software sync write strobe |
| soft_start | input | 1 | Software Start request bit |
| soft_hop | input | 1 | Software Hop request bit |
| sync_pins | input | 4 | External sync pins, asynchronous |
| pin_sel | input | 2 | Index of the watched sync pin |
| pin_start_en | input | 1 | Allow pin edges to trigger a start |
| pin_hop_en | input | 1 | Allow pin edges to trigger a hop |
| start_hold | input | 16 | Programmed start holdoff (0 disables, 1 immediate) |
| hop_hold | input | 16 | Programmed hop holdoff (0 disables, 1 immediate) |
| sleep_wr | input | 1 | Direct sleep flag write strobe |
| sleep_wdata | input | 1 | Value for a direct sleep write |
| grp_sleep_wr | input | 1 | Group sleep write strobe |
| grp_sleep_data | input | 4 | Group sleep bits, one per channel |
| sleep_o | output | 1 | Channel sleep flag |
| hop_stb | output | 1 | One-cycle frequency-hop strobe |
| realign_stb | output | 1 | One-cycle filter-phase realign strobe |

## Verification
The hardest situation to reach from the ports is a pending countdown that is silently cancelled. To get there, the bench starts a long hop countdown, reprograms the holdoff to 0 partway through, and issues a fresh request. It then watches long enough to prove that the original expiry never arrives. Two other cases need deliberately timed stimulus. In one, a sleep write and an immediate start are driven in the same cycle to expose the priority between them. In the other, a pin is held high for many cycles to show that one edge gives one action. Pin latency is measured against the software path, so that the synchroniser depth shows as a fixed two-cycle offset.

// File: rtl/chan_sync_pkg.sv
package chan_sync_pkg;
  // A pair of request lines, one per holdoff counter
  typedef struct packed {
    logic start;
    logic hop;
  } sync_req_t;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int N_PINS = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [DEPTH-1:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[DEPTH-2:0], pins_i[p]};
    end
    assign rise_o[p] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/holdoff_ctr.sv
module holdoff_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] hold_i,
  output logic          fire_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] cnt_q;

  // Idle is 0; a running count stays at 2 or above and fires on its step to 1
  assign fire_o = load_i ? (hold_i == ONE) : (tick_i && cnt_q == TWO);

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load_i)               cnt_q <= (hold_i > ONE) ? hold_i : '0;
    else if (fire_o)               cnt_q <= '0;
    else if (tick_i && cnt_q > TWO) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
  import chan_sync_pkg::*;
#(
  parameter int N_PINS    = 4,
  parameter int CW        = 16,
  parameter int SYNC_STG  = 2,
  parameter int GRP_CHANS = 4,
  parameter int CHAN_SLOT = 2,
  localparam int SW = $clog2(N_PINS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic                 soft_wr,
  input  logic                 soft_start,
  input  logic                 soft_hop,
  input  logic [N_PINS-1:0]    sync_pins,
  input  logic [SW-1:0]        pin_sel,
  input  logic                 pin_start_en,
  input  logic                 pin_hop_en,
  input  logic [CW-1:0]        start_hold,
  input  logic [CW-1:0]        hop_hold,
  input  logic                 sleep_wr,
  input  logic                 sleep_wdata,
  input  logic                 grp_sleep_wr,
  input  logic [GRP_CHANS-1:0] grp_sleep_data,
  output logic                 sleep_o,
  output logic                 hop_stb,
  output logic                 realign_stb
);
  logic [N_PINS-1:0] pin_rise;
  logic              sel_rise;
  sync_req_t         trig;
  logic              start_trig, hop_trig;
  logic              start_fire, hop_fire;
  logic [CW-1:0]     start_cnt, hop_cnt;
  logic              sleep_q, hop_q, realign_q;

  sync_edge_det #(.N_PINS(N_PINS), .STAGES(SYNC_STG)) u_edge (
    .clk(clk), .rst(rst), .pins_i(sync_pins), .rise_o(pin_rise)
  );

  assign sel_rise   = pin_rise[pin_sel];
  assign trig.start = (soft_wr && soft_start) || (pin_start_en && sel_rise);
  assign trig.hop   = (soft_wr && soft_hop)   || (pin_hop_en && sel_rise);
  assign start_trig = trig.start;
  assign hop_trig   = trig.hop;

  holdoff_ctr #(.CW(CW)) u_start (
    .clk(clk), .rst(rst), .tick_i(sample_en), .load_i(start_trig),
    .hold_i(start_hold), .fire_o(start_fire), .cnt_o(start_cnt)
  );

  holdoff_ctr #(.CW(CW)) u_hop (
    .clk(clk), .rst(rst), .tick_i(sample_en), .load_i(hop_trig),
    .hold_i(hop_hold), .fire_o(hop_fire), .cnt_o(hop_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q   <= 1'b1;
      hop_q     <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      hop_q     <= hop_fire;
      realign_q <= start_fire && !sleep_q;
      if (sleep_wr)          sleep_q <= sleep_wdata;
      else if (grp_sleep_wr) sleep_q <= grp_sleep_data[CHAN_SLOT];
      else if (start_fire)   sleep_q <= 1'b0;
    end
  end

  assign sleep_o     = sleep_q;
  assign hop_stb     = hop_q;
  assign realign_stb = realign_q;
endmodule

// File: rtl/chan_sync_chk.sv
module chan_sync_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_o,
  input logic          realign_stb,
  input logic          sleep_wr,
  input logic          grp_sleep_wr,
  input logic          hop_load,
  input logic [CW-1:0] hop_cnt,
  input logic          start_load,
  input logic [CW-1:0] start_cnt
);
  // R3
  realign_running_chk: assert property (@(posedge clk) disable iff (rst)
    realign_stb |-> $past(!sleep_o));

  // R9
  sleep_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(sleep_wr || grp_sleep_wr));

  // R7
  hop_no_climb_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(hop_load) |-> (hop_cnt <= $past(hop_cnt)));

  // R7
  start_no_climb_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(start_load) |-> (start_cnt <= $past(start_cnt)));

  // R2
  hop_skip_one_chk: assert property (@(posedge clk) disable iff (rst)
    hop_cnt != CW'(1));

  // R3
  start_skip_one_chk: assert property (@(posedge clk) disable iff (rst)
    start_cnt != CW'(1));
endmodule

bind chan_sync_ctrl chan_sync_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .sleep_o(sleep_o), .realign_stb(realign_stb),
  .sleep_wr(sleep_wr), .grp_sleep_wr(grp_sleep_wr),
  .hop_load(hop_trig), .hop_cnt(hop_cnt),
  .start_load(start_trig), .start_cnt(start_cnt)
);

// File: tb/sim_chan_sync_ctrl.sv
`timescale 1ns/1ps
module sim_chan_sync_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_en = 1'b1;
  logic        soft_wr = 1'b0, soft_start = 1'b0, soft_hop = 1'b0;
  logic [3:0]  sync_pins = '0;
  logic [1:0]  pin_sel = '0;
  logic        pin_start_en = 1'b0, pin_hop_en = 1'b0;
  logic [15:0] start_hold = 16'd1, hop_hold = 16'd1;
  logic        sleep_wr = 1'b0, sleep_wdata = 1'b0;
  logic        grp_sleep_wr = 1'b0;
  logic [3:0]  grp_sleep_data = '0;
  logic        sleep_o, hop_stb, realign_stb;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  chan_sync_ctrl u0 (
    .clk(clk), .rst(rst), .sample_en(sample_en), .soft_wr(soft_wr),
    .soft_start(soft_start), .soft_hop(soft_hop), .sync_pins(sync_pins),
    .pin_sel(pin_sel), .pin_start_en(pin_start_en), .pin_hop_en(pin_hop_en),
    .start_hold(start_hold), .hop_hold(hop_hold), .sleep_wr(sleep_wr),
    .sleep_wdata(sleep_wdata), .grp_sleep_wr(grp_sleep_wr),
    .grp_sleep_data(grp_sleep_data), .sleep_o(sleep_o), .hop_stb(hop_stb),
    .realign_stb(realign_stb)
  );

  // Vector: pin(1) start(1) presleep(1) psel(2) hold(16) expected latency(8)
  localparam int VW = 29;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 16'd1, 8'd1},
    {1'b0, 1'b0, 1'b0, 2'd0, 16'd4, 8'd4},
    {1'b1, 1'b0, 1'b0, 2'd1, 16'd1, 8'd3},
    {1'b1, 1'b0, 1'b0, 2'd3, 16'd6, 8'd8},
    {1'b0, 1'b1, 1'b1, 2'd0, 16'd3, 8'd3},
    {1'b0, 1'b1, 1'b0, 2'd0, 16'd1, 8'd1},
    {1'b1, 1'b1, 1'b1, 2'd2, 16'd2, 8'd4},
    {1'b1, 1'b1, 1'b0, 2'd0, 16'd5, 8'd7}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // which: 0 hop_stb, 1 sleep_o low, 2 realign_stb; returns 0 if none seen
  task automatic wait_evt(input int which, input int lim, output int lat);
    lat = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      soft_wr = 1'b0;
      sleep_wr = 1'b0;
      if ((which == 0 && hop_stb) || (which == 1 && !sleep_o) ||
          (which == 2 && realign_stb)) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic set_sleep(input logic v);
    sleep_wr = 1'b1; sleep_wdata = v;
    tick();
    sleep_wr = 1'b0;
  endtask

  task automatic soft_req(input logic st, input logic hp);
    soft_wr = 1'b1; soft_start = st; soft_hop = hp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, cnt;
    logic [VW-1:0] v;
    @(negedge clk);
    tick(); tick();
    // R1 during reset
    chk(sleep_o && !hop_stb && !realign_stb, "R1 reset state", {sleep_o, hop_stb, realign_stb}, 3'b100);
    rst = 1'b0;
    tick();
    chk(sleep_o && !hop_stb && !realign_stb, "R1 after reset", {sleep_o, hop_stb, realign_stb}, 3'b100);

    // Table walk: R2 R3 R5
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      set_sleep(v[26]);
      pin_sel = v[25:24];
      pin_start_en = v[27];
      pin_hop_en = !v[27];
      if (v[27]) start_hold = v[23:8]; else hop_hold = v[23:8];
      if (v[28]) sync_pins[v[25:24]] = 1'b1;
      else soft_req(v[27], !v[27]);
      wait_evt(v[27] ? (v[26] ? 1 : 2) : 0, 60, lat);
      chk(lat == int'(v[7:0]), v[28] ? "R5 pin latency" : (v[27] ? "R3 start latency" : "R2 hop latency"),
          lat, int'(v[7:0]));
      if (v[27] && !v[26]) chk(!sleep_o, "R3 stays running", sleep_o, 0);
      tick();
      chk(!hop_stb && !realign_stb, "R10 strobe width", {hop_stb, realign_stb}, 0);
      sync_pins = '0;
      repeat (4) tick();
    end
    pin_start_en = 1'b0; pin_hop_en = 1'b0;

    // R3 sleeping start gives no realign
    set_sleep(1'b1); start_hold = 16'd2;
    soft_req(1'b1, 1'b0);
    wait_evt(2, 10, lat);
    chk(lat == 0 && !sleep_o, "R3 no realign when asleep", lat, 0);

    // R5 long level triggers once; other pin ignored
    pin_sel = 2'd2; pin_hop_en = 1'b1; hop_hold = 16'd1;
    sync_pins[2] = 1'b1; cnt = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (hop_stb) cnt++; end
    chk(cnt == 1, "R5 held level fires once", cnt, 1);
    sync_pins = '0; repeat (4) tick();
    sync_pins[1] = 1'b1;
    wait_evt(0, 10, lat);
    chk(lat == 0, "R5 unselected pin ignored", lat, 0);
    sync_pins = '0; repeat (4) tick();

    // R6 disabled enable
    pin_hop_en = 1'b0; sync_pins[2] = 1'b1;
    wait_evt(0, 10, lat);
    chk(lat == 0, "R6 hop enable off", lat, 0);
    sync_pins = '0; repeat (4) tick();
    set_sleep(1'b1); pin_start_en = 1'b0; start_hold = 16'd1;
    sync_pins[2] = 1'b1;
    repeat (6) tick();
    chk(sleep_o, "R6 start enable off", sleep_o, 1);
    sync_pins = '0; repeat (4) tick();

    // R4 hold 0 does nothing and cancels pending
    hop_hold = 16'd0; soft_req(1'b0, 1'b1);
    wait_evt(0, 20, lat);
    chk(lat == 0, "R4 zero holdoff", lat, 0);
    hop_hold = 16'd30; soft_req(1'b0, 1'b1);
    wait_evt(0, 5, lat);
    hop_hold = 16'd0; soft_req(1'b0, 1'b1);
    wait_evt(0, 50, lat);
    chk(lat == 0, "R4 cancel pending", lat, 0);

    // R7 reload restarts count
    hop_hold = 16'd20; soft_req(1'b0, 1'b1);
    wait_evt(0, 10, lat);
    soft_req(1'b0, 1'b1);
    wait_evt(0, 40, lat);
    chk(lat == 20, "R7 reload latency", lat, 20);

    // R8 sample enable gating
    sample_en = 1'b0; hop_hold = 16'd3; soft_req(1'b0, 1'b1);
    wait_evt(0, 12, lat);
    chk(lat == 0, "R8 paused count", lat, 0);
    sample_en = 1'b1;
    wait_evt(0, 10, lat);
    chk(lat == 2, "R8 resume latency", lat, 2);
    sample_en = 1'b0; hop_hold = 16'd1; soft_req(1'b0, 1'b1);
    wait_evt(0, 5, lat);
    chk(lat == 1, "R8 immediate without tick", lat, 1);
    sample_en = 1'b1;

    // R9 direct, group and priority
    set_sleep(1'b0);
    chk(!sleep_o, "R9 direct write 0", sleep_o, 0);
    grp_sleep_wr = 1'b1; grp_sleep_data = 4'b0100; tick(); grp_sleep_wr = 1'b0;
    chk(sleep_o, "R9 group slot bit 1", sleep_o, 1);
    grp_sleep_wr = 1'b1; grp_sleep_data = 4'b1011; tick(); grp_sleep_wr = 1'b0;
    chk(!sleep_o, "R9 group slot bit 0", sleep_o, 0);
    set_sleep(1'b1);
    start_hold = 16'd1; soft_req(1'b1, 1'b0);
    sleep_wr = 1'b1; sleep_wdata = 1'b1;
    tick(); soft_wr = 1'b0; sleep_wr = 1'b0;
    chk(sleep_o, "R9 write beats start", sleep_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule